// File: doc/BRIEF.md
# Reload-Timer Serial Baud Generator

This block turns the system clock into the two timing strobes that a serial port needs. A fixed divide-by-12 prescaler feeds an 8-bit up-counter. When the counter wraps past its top value it loads itself from a programmable reload byte, so each wrap comes 256 minus the reload value prescaled steps after the previous one. The wrap pulses then pass through a halving stage, which the rate-doubling input can bypass. The result is a 16x oversampling strobe. A final divide-by-16 turns this into the once-per-bit strobe.

Software sets the reload byte to select the bit rate and sets the doubling input to choose between the two rate families. A run input starts the generator and freezes it. The bit rate is f_clk · 2^dbl / (32 · 12 · (256 − reload)). With an 11.0592 MHz clock, a reload of 253 and no doubling, this gives 9600 bit/s.

Top module: `baud_tick_gen`

## Requirements
- R1: The prescaler advances the reload counter once every 12 clock cycles while `run_en` is 1.
- R2: With `dbl_rate` = 1, `ovs_tick` is a one-cycle pulse that repeats every 12·(256 − `reload_val`) clock cycles. `reload_val` is read as an unsigned byte from 0 to 255.
- R3: With `dbl_rate` = 0, the halving stage is in the path and the `ovs_tick` period is 24·(256 − `reload_val`) cycles. With `dbl_rate` = 1, the halving stage is bypassed.
- R4: `bit_tick` is asserted only together with `ovs_tick`, on every 16th `ovs_tick`.
- R5: With `reload_val` = 253 and `dbl_rate` = 0, the `bit_tick` period is 1152 cycles. This is 9600 bit/s from an 11.0592 MHz clock.
- R6: With `reload_val` = 232 (−24) and `dbl_rate` = 0, the `bit_tick` period is 9216 cycles. With `reload_val` = 244 (−12) and `dbl_rate` = 1, it is 2304 cycles.
- R7: While `run_en` is 0, neither strobe is asserted and every divider holds its state. Resuming continues the interval that was in progress, so the number of running cycles between strobes does not change.
- R8: A new `reload_val` does not alter the count in progress. It is used from the next wrap onward.
- R9: Reset clears the prescaler, the counter and all later dividers. With `dbl_rate` = 1 and `run_en` = 1 held from reset release, the first `ovs_tick` appears after 3071 rising edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | 1 runs the generator; 0 freezes all dividers |
| dbl_rate | input | 1 | 1 bypasses the halving stage, doubling the rate |
| reload_val | input | 8 | Counter reload value used on each wrap |
| ovs_tick | output | 1 | 16x oversampling strobe, one cycle wide |
| bit_tick | output | 1 | Bit-rate strobe, one cycle wide |

## Verification
The bench sweeps the reload byte across its upper range in both doubling settings and compares each strobe period with the arithmetic formula. A counter that reloads one step late, or that counts through the reload value, shows up as an off-by-one period. A halver wired with the wrong polarity shows up as a period that is doubled or halved.

The bench also does three timing tests:
- It changes the reload byte just after a wrap. A design that reloads at once gives a short first interval.
- It stops and restarts the run input in the middle of an interval. A design whose prescaler keeps running while stopped loses phase.
- It measures the exact first strobe after reset. Any divider that is not cleared shifts this strobe.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;
    parameter int unsigned PRESCALE_DEF = 12;
    parameter int unsigned COUNT_W_DEF  = 8;
    parameter int unsigned OVS_DEF      = 16;

    function automatic int unsigned width_for(input int unsigned n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction
endpackage

// File: rtl/baud_prescale.sv
module baud_prescale #(
    parameter int unsigned DIV = baud_gen_pkg::PRESCALE_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int unsigned W = baud_gen_pkg::width_for(DIV);
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    typedef struct packed {
        logic [W-1:0] cnt;
    } pre_state_t;

    pre_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        tick_o = run_i && (st_q.cnt == LAST);
        if (run_i) begin
            st_d.cnt = tick_o ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    a_r1_prescale_range: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LAST);
    a_r7_prescale_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> $stable(st_q.cnt));
endmodule

// File: rtl/baud_reload_cnt.sv
module baud_reload_cnt #(
    parameter int unsigned W = baud_gen_pkg::COUNT_W_DEF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step_i,
    input  logic [W-1:0] reload_i,
    output logic         wrap_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        wrap_o = step_i && (st_q.cnt == {W{1'b1}});
        if (step_i) begin
            st_d.cnt = wrap_o ? reload_i : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    a_r8_load_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> st_q.cnt == $past(reload_i));
    a_r7_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> $stable(st_q.cnt));
endmodule

// File: rtl/baud_halve.sv
module baud_halve (
    input  logic clk,
    input  logic rst_n,
    input  logic wrap_i,
    input  logic dbl_i,
    output logic tick_o
);
    typedef struct packed {
        logic half;
    } half_state_t;

    half_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        tick_o = dbl_i ? wrap_i : (wrap_i && st_q.half);
        if (wrap_i && !dbl_i) begin
            st_d.half = ~st_q.half;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    a_r3_bypass_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (dbl_i && wrap_i) |-> tick_o);
    a_r3_halve_toggles: assert property (@(posedge clk) disable iff (!rst_n)
        (!dbl_i && wrap_i) |=> st_q.half != $past(st_q.half));
endmodule

// File: rtl/baud_ovs_div.sv
module baud_ovs_div #(
    parameter int unsigned N = baud_gen_pkg::OVS_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ovs_i,
    output logic bit_o
);
    localparam int unsigned W = baud_gen_pkg::width_for(N);
    localparam logic [W-1:0] LAST = W'(N - 1);

    typedef struct packed {
        logic [W-1:0] cnt;
    } div_state_t;

    div_state_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        bit_o = ovs_i && (st_q.cnt == LAST);
        if (ovs_i) begin
            st_d.cnt = bit_o ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    a_r4_div_range: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LAST);
    a_r4_div_steps: assert property (@(posedge clk) disable iff (!rst_n)
        ovs_i |=> st_q.cnt != $past(st_q.cnt));
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
    parameter int unsigned PRESCALE = baud_gen_pkg::PRESCALE_DEF,
    parameter int unsigned COUNT_W  = baud_gen_pkg::COUNT_W_DEF,
    parameter int unsigned OVS      = baud_gen_pkg::OVS_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_en,
    input  logic               dbl_rate,
    input  logic [COUNT_W-1:0] reload_val,
    output logic               ovs_tick,
    output logic               bit_tick
);
    logic pre_tick;
    logic wrap;

    baud_prescale #(.DIV(PRESCALE)) u_pre (
        .clk(clk), .rst_n(rst_n), .run_i(run_en), .tick_o(pre_tick)
    );

    baud_reload_cnt #(.W(COUNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .step_i(pre_tick),
        .reload_i(reload_val), .wrap_o(wrap)
    );

    baud_halve u_half (
        .clk(clk), .rst_n(rst_n), .wrap_i(wrap), .dbl_i(dbl_rate),
        .tick_o(ovs_tick)
    );

    baud_ovs_div #(.N(OVS)) u_div (
        .clk(clk), .rst_n(rst_n), .ovs_i(ovs_tick), .bit_o(bit_tick)
    );

    a_r4_bit_with_ovs: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> ovs_tick);
    a_r7_quiet_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |-> (!ovs_tick && !bit_tick));
    a_r2_ovs_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (ovs_tick && reload_val != 8'hFF) |=> !ovs_tick);
endmodule

// File: tb/baud_tick_gen_test.sv
`timescale 1ns/1ps
module baud_tick_gen_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run_en = 1'b0;
    logic dbl_rate = 1'b1;
    logic [7:0] reload_val = 8'd0;
    logic ovs_tick, bit_tick;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    baud_tick_gen uut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .dbl_rate(dbl_rate),
        .reload_val(reload_val), .ovs_tick(ovs_tick), .bit_tick(bit_tick)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // starts at a negedge; counts rising edges until the chosen strobe is seen at a negedge
    task automatic gap(input bit use_bit, output int n);
        n = 0;
        do begin
            @(posedge clk); n++;
            @(negedge clk);
        end while (!(use_bit ? bit_tick : ovs_tick));
    endtask

    task automatic skip(input bit use_bit, input int k);
        int dummy;
        for (int i = 0; i < k; i++) gap(use_bit, dummy);
    endtask

    initial begin
        int n;
        int cnt16;
        @(negedge clk);
        // R9: reset state
        chk("R9 ovs in reset", int'(ovs_tick), 0);
        chk("R9 bit in reset", int'(bit_tick), 0);
        run_en = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        gap(1'b0, n);
        chk("R9 first strobe after reset", n, 3071);

        // R1 R2: sweep with doubling on
        for (int r = 236; r <= 255; r++) begin
            reload_val = 8'(r);
            skip(1'b0, 2);
            gap(1'b0, n);
            chk("R2 ovs period dbl=1", n, 12 * (256 - r));
        end
        reload_val = 8'd0;
        skip(1'b0, 2);
        gap(1'b0, n);
        chk("R1 ovs period reload 0", n, 3072);

        // R3: sweep with halving stage in path
        dbl_rate = 1'b0;
        for (int r = 236; r <= 255; r++) begin
            reload_val = 8'(r);
            skip(1'b0, 2);
            gap(1'b0, n);
            chk("R3 ovs period dbl=0", n, 24 * (256 - r));
        end

        // R5: 9600 setting
        reload_val = 8'd253;
        skip(1'b1, 1);
        gap(1'b1, n);
        chk("R5 bit period 9600", n, 1152);

        // R4: 16 ovs strobes per bit strobe
        cnt16 = 0;
        do begin
            gap(1'b0, n);
            cnt16++;
        end while (!bit_tick);
        chk("R4 ovs per bit", cnt16, 16);

        // R6: other rates
        reload_val = 8'd232;
        skip(1'b1, 1);
        gap(1'b1, n);
        chk("R6 bit period 1200", n, 9216);
        dbl_rate = 1'b1;
        reload_val = 8'd244;
        skip(1'b1, 1);
        gap(1'b1, n);
        chk("R6 bit period doubled", n, 2304);

        // R8: reload change mid-count
        reload_val = 8'd250;
        skip(1'b0, 2);
        @(posedge clk);
        @(negedge clk);
        reload_val = 8'd240;
        gap(1'b0, n);
        n = n + 1;
        chk("R8 interval keeps old reload", n, 72);
        gap(1'b0, n);
        chk("R8 new reload next interval", n, 192);

        // R7: stop and resume
        reload_val = 8'd200;
        skip(1'b0, 2);
        repeat (100) @(negedge clk);
        run_en = 1'b0;
        cnt16 = 0;
        for (int i = 0; i < 500; i++) begin
            @(negedge clk);
            if (ovs_tick || bit_tick) cnt16++;
        end
        chk("R7 no strobe while stopped", cnt16, 0);
        run_en = 1'b1;
        gap(1'b0, n);
        chk("R7 running cycles across stop", n + 100, 672);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule